// File: doc/BRIEF.md
# SPI Master/Slave Byte Port

This block is a synchronous serial port that runs as either the clocking side (master) or the clocked side (slave) of an SPI link. Each transfer moves one 8-bit byte out on the serial data output and one byte in from the serial data input at the same time. The serial data passes through an internal shift register that the host never sees. The host writes a byte to load that shift register. A completed byte is copied into a separate receive holding register, which the host drains through a valid/ready handshake.

A 4-bit mode field picks the role and the clock source. In master mode the serial clock comes from the system clock divided by 4, 16 or 64, or from an external timer tick divided by 2. In slave mode the block follows an external serial clock, with or without a slave-select input. Clock idle level, clock phase and the master's input sample point are programmable. A one-cycle done pulse marks each finished byte. A sticky collision flag records writes made while busy, and a sticky overflow flag records bytes that arrived while the holding register was still full.

The receive side is a stream: `rx_valid` holds, with `rx_data` stable, until `rx_ready` is seen high on a clock edge. A completion that arrives on the cycle of that acceptance refills the register without loss. The write side does not stall: `wr_ready` only reports whether a write would be accepted. A write offered while `wr_ready` is low is dropped and raises the collision flag, unless the port is disabled or the mode is unused.

Top module: `spi_port`

## Requirements
- R1: Each transfer shifts exactly 8 bits. The byte on `sdo` goes out most significant bit first while 8 bits from `sdi` are taken in, so a master with `sdi` tied to `sdo` receives the byte it sent, in all four clock modes.
- R2: In master mode `sck_o` rests at `cfg_cpol` while idle. A transfer gives exactly 16 `sck_o` transitions, after which it returns to `cfg_cpol`. With `cfg_cpha`=0 data is taken on the first (leading) edge of each clock period; with `cfg_cpha`=1 it is taken on the second (trailing) edge.
- R3: In master mode `cfg_smp`=0 samples `sdi` on the capture edge, in the middle of the bit. `cfg_smp`=1 samples half an SCK period later, at the end of the bit. A slave that changes `sdi` just after each leading edge of a mode-0 clock is therefore received whole with `cfg_smp`=1, and shifted right by one with `cfg_smp`=0.
- R4: Mode codes: 0, 1 and 2 select master with an SCK period of 4, 16 and 64 system clocks. Code 3 selects master with an SCK period of two `tmr_tick` pulses. Code 4 selects slave with `ss_n` in use, and code 5 selects slave that ignores `ss_n`. Any other code is inactive: `wr_ready` stays low, writes are ignored and `sck_o` does not move.
- R5: At the end of a byte, `done` is high for exactly one cycle and the byte appears on `rx_data` with `rx_valid` high one cycle later. Acceptance (`rx_valid` and `rx_ready` both high on a clock edge) clears `rx_valid`.
- R6: If a byte completes while `rx_valid` is high and not being accepted, `rx_data` keeps the older byte and `ovf` is set and stays set.
- R7: A write while a transfer is in progress is ignored, does not disturb the transfer, and sets the sticky `wcol` flag.
- R8: In mode 4, `ss_n` high resets the bit count, ignores `sck_i` and puts `sdo` in high impedance (`sdo_oe` low). A new write is then accepted, and after `ss_n` returns low a full new byte is exchanged with a single `done`.
- R9: With `enable` low the port is idle: `sdo_oe` and `wr_ready` are low, any transfer is abandoned, and `rx_valid`, `ovf` and `wcol` are cleared.
- R10: In slave mode, with `cfg_cpol`=0 and `cfg_cpha`=0, the port presents the written byte's most significant bit on `sdo` before the first rising `sck_i` edge. It takes `sdi` on rising edges and moves `sdo` to the next bit on falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable; low holds the port idle and clears the flags |
| cfg_mode | input | 4 | Role and clock source code |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| cfg_smp | input | 1 | Master sample point: 0 mid-bit, 1 end of bit |
| tmr_tick | input | 1 | One-cycle timer pulse used by mode 3 |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DATA_W (8) | Byte to transmit |
| wr_ready | output | 1 | A write would be accepted this cycle |
| rx_data | output | DATA_W (8) | Receive holding register |
| rx_valid | output | 1 | Holding register full |
| rx_ready | input | 1 | Host accepts the held byte |
| done | output | 1 | One-cycle pulse at the end of each byte |
| ovf | output | 1 | Sticky receive overflow |
| wcol | output | 1 | Sticky write collision |
| sck_i | input | 1 | Serial clock from the master (slave modes) |
| sck_o | output | 1 | Serial clock driven in master modes |
| ss_n | input | 1 | Slave select, active low (mode 4) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The master path is tried in loopback with every combination of idle level, clock phase and sample point. This separates a wrong bit order or count from a wrong edge choice, because a wrong edge loses or repeats a bit. A bench slave that changes its data just after each leading edge tells the two sample points apart: only the end-of-bit setting returns the byte intact. Back-to-back bytes with the host not reading, writes during a transfer, a slave byte cut short by slave-select, and an unused mode code separate the overflow, collision, abort and ignore paths from the normal flow.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam logic [3:0] MODE_M_DIVA = 4'd0;
  localparam logic [3:0] MODE_M_DIVB = 4'd1;
  localparam logic [3:0] MODE_M_DIVC = 4'd2;
  localparam logic [3:0] MODE_M_TMR  = 4'd3;
  localparam logic [3:0] MODE_S_SEL  = 4'd4;
  localparam logic [3:0] MODE_S_FREE = 4'd5;

  function automatic logic mode_is_master(input logic [3:0] m);
    return m <= MODE_M_TMR;
  endfunction

  function automatic logic mode_is_slave(input logic [3:0] m);
    return (m == MODE_S_SEL) || (m == MODE_S_FREE);
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= RST_VAL;
        else if (i == 0) stage[i] <= d;
        else stage[i] <= stage[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       tmr_tick,
  output logic       half_tick
);
  localparam int HALF_A = DIV_A / 2;
  localparam int HALF_B = DIV_B / 2;
  localparam int HALF_C = DIV_C / 2;
  localparam int CW     = (HALF_C > 2) ? $clog2(HALF_C) : 1;

  logic [CW-1:0] cnt, lim;

  always_comb begin
    case (sel)
      2'd0:    lim = CW'(HALF_A - 1);
      2'd1:    lim = CW'(HALF_B - 1);
      default: lim = CW'(HALF_C - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign half_tick = run && ((sel == 2'd3) ? tmr_tick : (cnt == lim));
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [3:0]        mode,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              smp,
  input  logic              half_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sck_i,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              sck_o,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              mst_run,
  output logic              done,
  output logic [DATA_W-1:0] done_data
);
  localparam int TW = $clog2(2*DATA_W + 1);
  localparam int CW = $clog2(DATA_W);
  localparam logic [TW-1:0] T_END    = TW'(2*DATA_W);
  localparam logic [TW-1:0] SAMP_SPAN = TW'(2*DATA_W - 2);
  localparam logic [TW-1:0] SHFT_SPAN = TW'(2*DATA_W - 4);
  localparam logic [CW-1:0] LAST_BIT  = CW'(DATA_W - 1);

  logic is_m, is_s, ss_block;
  logic sck_s, sdi_s, ss_s, sck_d;
  logic rise, fall, lead, trail, s_samp, s_shft;
  logic [DATA_W-1:0] out_sr, in_sr, nxt_in_m, nxt_in_s;
  logic              m_busy, phase;
  logic [TW-1:0]     t, samp_lo, shft_lo, d_samp, d_shft;
  logic              m_samp, m_shft;
  logic [CW-1:0]     s_cnt;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_i, sdi, ss_n}), .q({sck_s, sdi_s, ss_s})
  );

  assign is_m     = mode_is_master(mode);
  assign is_s     = mode_is_slave(mode);
  assign ss_block = (mode == MODE_S_SEL) && ss_s;

  // slave edge decode
  assign rise   = sck_s & ~sck_d;
  assign fall   = ~sck_s & sck_d;
  assign lead   = cpol ? fall : rise;
  assign trail  = cpol ? rise : fall;
  assign s_samp = cpha ? trail : lead;
  assign s_shft = cpha ? lead : trail;

  // master half-tick schedule: tick index t runs 0..2*DATA_W
  always_comb begin
    samp_lo = TW'(cpha) + TW'(smp);
    shft_lo = TW'(1) + TW'(cpha);
    d_samp  = t - samp_lo;
    d_shft  = t - shft_lo;
    m_samp  = (t >= samp_lo) && (d_samp <= SAMP_SPAN) && !d_samp[0];
    m_shft  = (t >= shft_lo) && (d_shft <= SHFT_SPAN) && !d_shft[0];
  end

  assign nxt_in_m = {in_sr[DATA_W-2:0], sdi};
  assign nxt_in_s = {in_sr[DATA_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d     <= 1'b0;
      out_sr    <= '0;
      in_sr     <= '0;
      m_busy    <= 1'b0;
      phase     <= 1'b0;
      t         <= '0;
      s_cnt     <= '0;
      done      <= 1'b0;
      done_data <= '0;
    end else begin
      sck_d <= sck_s;
      done  <= 1'b0;

      // master sequencing
      if (!enable || !is_m) begin
        m_busy <= 1'b0;
        t      <= '0;
        phase  <= 1'b0;
      end else if (load) begin
        m_busy <= 1'b1;
        t      <= '0;
        phase  <= 1'b0;
      end else if (m_busy && half_tick) begin
        if (t != T_END) phase <= ~phase;
        if (m_samp)     in_sr <= nxt_in_m;
        if (m_shft)     out_sr <= out_sr << 1;
        if (t == T_END) begin
          m_busy    <= 1'b0;
          done      <= 1'b1;
          done_data <= m_samp ? nxt_in_m : in_sr;
        end
        t <= t + 1'b1;
      end

      // slave sequencing
      if (!enable || !is_s || ss_block) begin
        s_cnt <= '0;
      end else begin
        if (s_samp) begin
          in_sr <= nxt_in_s;
          if (s_cnt == LAST_BIT) begin
            s_cnt     <= '0;
            done      <= 1'b1;
            done_data <= nxt_in_s;
          end else begin
            s_cnt <= s_cnt + 1'b1;
          end
        end
        if (s_shft && (s_cnt != '0)) out_sr <= out_sr << 1;
      end

      // host load (only accepted while idle)
      if (load) out_sr <= load_data;
    end
  end

  assign sck_o   = (enable && is_m) ? (cpol ^ phase) : cpol;
  assign sdo     = out_sr[DATA_W-1];
  assign sdo_oe  = enable && (is_m || (is_s && !ss_block));
  assign busy    = m_busy || (s_cnt != '0);
  assign mst_run = m_busy;
endmodule

// File: rtl/spi_host_buf.sv
module spi_host_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mode_ok,
  input  logic              busy,
  input  logic              wr_en,
  input  logic              done,
  input  logic [DATA_W-1:0] done_data,
  input  logic              rx_ready,
  output logic              load,
  output logic              wr_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              ovf,
  output logic              wcol
);
  logic coll, take;

  assign wr_ready = enable && mode_ok && !busy;
  assign load     = wr_en && wr_ready;
  assign coll     = wr_en && enable && mode_ok && busy;
  assign take     = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      ovf      <= 1'b0;
      wcol     <= 1'b0;
    end else if (!enable) begin
      rx_valid <= 1'b0;
      ovf      <= 1'b0;
      wcol     <= 1'b0;
    end else begin
      if (coll) wcol <= 1'b1;
      if (done) begin
        if (!rx_valid || take) begin
          rx_data  <= done_data;
          rx_valid <= 1'b1;
        end else begin
          ovf <= 1'b1;
        end
      end else if (take) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16,
  parameter int DIV_C       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [3:0]        cfg_mode,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_smp,
  input  logic              tmr_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              done,
  output logic              ovf,
  output logic              wcol,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe
);
  logic              half_tick, load, busy, mst_run, mode_ok;
  logic [DATA_W-1:0] done_data;

  assign mode_ok = mode_is_master(cfg_mode) || mode_is_slave(cfg_mode);

  spi_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(mst_run), .sel(cfg_mode[1:0]),
    .tmr_tick(tmr_tick), .half_tick(half_tick)
  );

  spi_engine #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(cfg_mode),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .smp(cfg_smp),
    .half_tick(half_tick), .load(load), .load_data(wr_data),
    .sck_i(sck_i), .ss_n(ss_n), .sdi(sdi),
    .sck_o(sck_o), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy),
    .mst_run(mst_run), .done(done), .done_data(done_data)
  );

  spi_host_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_ok(mode_ok),
    .busy(busy), .wr_en(wr_en), .done(done), .done_data(done_data),
    .rx_ready(rx_ready), .load(load), .wr_ready(wr_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .ovf(ovf), .wcol(wcol)
  );
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [3:0]        cfg_mode,
  input logic              cfg_cpol,
  input logic              wr_en,
  input logic              wr_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              done,
  input logic              ovf,
  input logic              wcol,
  input logic              sck_o,
  input logic              ss_n,
  input logic              sdo_oe
);
  logic is_master, mode_ok;
  assign is_master = (cfg_mode <= 4'd3);
  assign mode_ok   = is_master || (cfg_mode == 4'd4) || (cfg_mode == 4'd5);

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && is_master && wr_ready) |-> (sck_o == cfg_cpol));

  p_done_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && enable) |=> rx_valid);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(rx_data));

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && enable && rx_valid && !rx_ready) |=> ovf);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && enable) |=> ovf);

  p_wcol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && enable && mode_ok && !wr_ready) |=> wcol);

  p_ss_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cfg_mode == 4'd4 && ss_n && $past(ss_n) && $past(ss_n, 2)
     && $past(ss_n, 3)) |-> !sdo_oe);

  p_idle_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!sdo_oe && !wr_ready));

  p_idle_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rx_valid && !ovf && !wcol));
endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_mode(cfg_mode),
  .cfg_cpol(cfg_cpol), .wr_en(wr_en), .wr_ready(wr_ready),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .done(done), .ovf(ovf), .wcol(wcol), .sck_o(sck_o), .ss_n(ss_n),
  .sdo_oe(sdo_oe)
);

// File: tb/spi_port_tb_top.sv
`timescale 1ns/1ps
module spi_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] cfg_mode = 4'd0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_smp = 1'b0;
  logic       tmr_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       done, ovf, wcol;
  logic       sck_i = 1'b0, sck_o, ss_n = 1'b1;
  logic       sdi, sdo, sdo_oe;
  logic       lb = 1'b1, model_on = 1'b0;
  logic       sdi_drv = 1'b0, sdi_mdl = 1'b0;
  logic [7:0] mdl_sr = 8'h00;
  logic       tmr_on = 1'b0;
  logic       auto_read = 1'b1;

  int checks = 0, errors = 0;
  int cyc = 0, tog_cnt = 0, last_tog = 0, gap = 0, done_cnt = 0;
  logic sck_prev = 1'b0;
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  assign sdi = lb ? sdo : (model_on ? sdi_mdl : sdi_drv);

  spi_port dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_mode(cfg_mode),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_smp(cfg_smp),
    .tmr_tick(tmr_tick), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ready(wr_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .done(done), .ovf(ovf), .wcol(wcol),
    .sck_i(sck_i), .sck_o(sck_o), .ss_n(ss_n), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // timer source: one pulse every 5 cycles
  always @(posedge clk) begin : g_tmr
    int k;
    k = cyc % 5;
    tmr_tick <= tmr_on && (k == 0);
  end

  // monitor: scoreboard, edge bookkeeping, slave data model
  always @(negedge clk) begin
    cyc++;
    if (sck_o != sck_prev) begin
      tog_cnt++;
      gap = cyc - last_tog;
      last_tog = cyc;
      if (model_on && (sck_o != cfg_cpol)) begin
        sdi_mdl = mdl_sr[7];
        mdl_sr  = mdl_sr << 1;
      end
    end
    sck_prev = sck_o;
    if (done) done_cnt++;
    if (rx_ready) rx_ready = 1'b0;
    else if (rx_valid && auto_read) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected byte", rx_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R1", "received byte", rx_data, e);
      end
      rx_ready = 1'b1;
    end
  end

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic mxfer(input logic [7:0] d);
    write_byte(d);
    while (!wr_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // bench master for slave tests: cpol=0, cpha=0, half period 8 cycles
  task automatic sxfer(input logic [7:0] m, input int nbits,
                       output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      sdi_drv = m[7-i];
      repeat (8) @(negedge clk);
      got = {got[6:0], sdo};
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin : g_watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : g_main
    int t0, d0;
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9: idle state while disabled
    chk(!rx_valid && !sdo_oe && !wr_ready && !ovf && !wcol, "R9",
        "reset/idle outputs", {rx_valid, sdo_oe, wr_ready, ovf, wcol}, 0);

    enable = 1'b1;
    cfg_mode = 4'd0;
    @(negedge clk);
    chk(wr_ready && sck_o == 1'b0, "R2", "idle sck and ready",
        {wr_ready, sck_o}, 2'b10);

    // R1 R2: loopback in all clock modes and sample points
    for (int c = 0; c < 8; c++) begin
      logic [7:0] d;
      cfg_cpol = c[0];
      cfg_cpha = c[1];
      cfg_smp  = c[2];
      d = 8'hA1 ^ 8'(c * 37);
      repeat (2) @(negedge clk);
      t0 = tog_cnt;
      d0 = done_cnt;
      exp_q.push_back(d);
      mxfer(d);
      chk(tog_cnt - t0 == 16, "R2", "sck transitions", tog_cnt - t0, 16);
      chk(sck_o == cfg_cpol, "R2", "sck returns idle", sck_o, cfg_cpol);
      chk(done_cnt - d0 == 1, "R5", "one done pulse", done_cnt - d0, 1);
    end
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_smp = 1'b0;

    // R4: clock rates
    for (int m = 0; m < 4; m++) begin
      int per;
      cfg_mode = 4'(m);
      if (m == 3) tmr_on = 1'b1;
      per = (m == 0) ? 4 : (m == 1) ? 16 : (m == 2) ? 64 : 10;
      exp_q.push_back(8'h5C);
      mxfer(8'h5C);
      chk(2 * gap == per, "R4", "sck period", 2 * gap, per);
      tmr_on = 1'b0;
    end
    cfg_mode = 4'd0;

    // R3: sample point against a late-changing slave
    lb = 1'b0;
    model_on = 1'b1;
    for (int s = 0; s < 2; s++) begin
      cfg_smp = s[0];
      sdi_mdl = 1'b0;
      mdl_sr  = 8'hB5;
      exp_q.push_back(s ? 8'hB5 : 8'h5A);
      mxfer(8'h00);
      chk(exp_q.size() == 0, "R3", "sample point byte drained",
          exp_q.size(), 0);
    end
    model_on = 1'b0;
    lb = 1'b1;
    cfg_smp = 1'b0;

    // R6: overflow keeps the older byte
    auto_read = 1'b0;
    exp_q.push_back(8'h3C);
    mxfer(8'h3C);
    mxfer(8'hC3);
    chk(ovf && rx_valid && rx_data == 8'h3C, "R6", "overflow hold",
        {ovf, rx_valid, rx_data}, {2'b11, 8'h3C});
    auto_read = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rx_valid, "R5", "read clears full", rx_valid, 0);

    // R7: write collision
    chk(!wcol, "R7", "wcol clear before", wcol, 0);
    exp_q.push_back(8'h96);
    write_byte(8'h96);
    repeat (5) @(negedge clk);
    write_byte(8'h69);
    while (!wr_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(wcol && exp_q.size() == 0, "R7", "wcol set, transfer intact",
        {wcol, 8'(exp_q.size())}, {1'b1, 8'h00});

    // R9: disable clears flags
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(!ovf && !wcol && !sdo_oe && !wr_ready, "R9", "disable clears",
        {ovf, wcol, sdo_oe, wr_ready}, 0);
    enable = 1'b1;

    // R4: unused mode ignores writes
    cfg_mode = 4'd7;
    t0 = tog_cnt;
    write_byte(8'hFF);
    repeat (60) @(negedge clk);
    chk(!wr_ready && !wcol && tog_cnt == t0 && !rx_valid, "R4",
        "unused mode inert", {wr_ready, wcol, 8'(tog_cnt - t0)}, 0);

    // R8 R10: slave with select, aborted then full byte
    lb = 1'b0;
    cfg_mode = 4'd4;
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    write_byte(8'hE7);
    d0 = done_cnt;
    sxfer(8'h11, 3, got);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!sdo_oe && wr_ready, "R8", "select high floats and resets",
        {sdo_oe, wr_ready}, 2'b01);
    write_byte(8'h4D);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    exp_q.push_back(8'hA6);
    sxfer(8'hA6, 8, got);
    chk(got == 8'h4D, "R10", "slave sdo byte", got, 8'h4D);
    chk(done_cnt - d0 == 1, "R8", "single done after restart",
        done_cnt - d0, 1);
    repeat (4) @(negedge clk);

    // R4 R10: slave ignoring select
    cfg_mode = 4'd5;
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    write_byte(8'h2B);
    exp_q.push_back(8'hD2);
    sxfer(8'hD2, 8, got);
    chk(got == 8'h2B && sdo_oe, "R10", "slave without select",
        {sdo_oe, got}, {1'b1, 8'h2B});
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule